// File: doc/BRIEF.md
# Joinable Transmit/Receive Word Queue Pair

This block holds the two word queues that sit between a processor and one small programmable I/O machine. The transmit queue carries 32-bit words from the processor to the machine (processor writes, machine pulls). The receive queue carries words the other way (machine pushes, processor reads). Each queue has 4 entries of its own. Both queues live in one array of 8 words: transmit uses entries 0 to 3 and receive uses entries 4 to 7.

The storage can be reassigned. In transmit-join mode the transmit queue takes all 8 entries. In receive-join mode the receive queue takes them instead. The receive half can also be turned into four randomly addressed registers. The machine can store into them (put), read from them (get), or both. The processor reaches whichever side the machine leaves free.

Misuse does no harm: a write to a full queue or a read from an empty one leaves the queue as it was. Each such event raises a sticky debug flag, which is cleared by writing 1. A level-compare output gives a whole-word mask that the machine can test against a threshold.

Top module: `fifo_pair_join`

## Requirements
- R1: The transmit queue returns processor words to the machine in first-in first-out order and holds 4 words. `txLevel` gives its fill count. `txFull` is high when the count reaches capacity and `txEmpty` is high at 0. `smPullData` is 0 whenever the queue is empty.
- R2: The receive queue returns machine words to the processor in first-in first-out order and holds 4 words. It reports `rxLevel`, `rxFull` and `rxEmpty` the same way. `cpuRxRdData` is 0 whenever the queue is empty.
- R3: With `cfgJoinTx` high and no random-access bit set, the transmit queue holds 8 words. The receive queue then shows level 0 with `rxFull` and `rxEmpty` both high. If both join bits are high, transmit join wins.
- R4: With only `cfgJoinRx` high and no random-access bit set, the receive queue holds 8 words. The transmit queue then shows level 0 with `txFull` and `txEmpty` both high.
- R5: In the cycle where the effective mode changes, both queues are emptied. The mode is made of effective transmit join, effective receive join, and random access on or off. Every queue and storage operation in that cycle is ignored, no flag is raised, and all read data is 0.
- R6: A processor write to a full transmit queue is dropped and sets flag bit 2. A machine push to a full receive queue is dropped and sets flag bit 0. Neither changes the queue.
- R7: A processor read of an empty receive queue returns 0 and sets flag bit 1. A machine pull from an empty transmit queue returns 0 and sets flag bit 3. Neither changes the queue.
- R8: A 1 in bit i of `dbgClr` clears flag bit i. A flag event in the same cycle wins over the clear.
- R9: When `cfgRaPut` or `cfgRaGet` is high, both join bits are ignored. The transmit queue keeps 4 entries, and the receive queue shows level 0 with `rxFull` and `rxEmpty` both high.
- R10: In random-access mode, `smPutEn` writes receive entry `smPutIdx` when put is on. `smGetData` returns entry `smGetIdx` when get is on, and 0 otherwise. The processor may read entries (`cpuRaRdData`) only when put is on alone, and write them (`cpuRaWrEn`) only when get is on alone. When both are on, processor reads return 0 and processor writes are ignored.
- R11: `statOut` is all ones when the selected level is below `statN`, and all zeros otherwise. `statSel` 0 selects the transmit level and 1 selects the receive level.
- R12: A write and a pull on the same queue in the same cycle are judged on the state before the edge. On a queue that is neither full nor empty, the level stays the same. On an empty transmit queue the write is stored, while the pull returns 0 and raises flag bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgJoinTx | input | 1 | Transmit queue takes all storage |
| cfgJoinRx | input | 1 | Receive queue takes all storage |
| cfgRaPut | input | 1 | Random access: machine may put |
| cfgRaGet | input | 1 | Random access: machine may get |
| cpuTxWrEn | input | 1 | Processor write to transmit queue |
| cpuTxWrData | input | 32 | Processor write word |
| cpuRxRdEn | input | 1 | Processor read (pop) from receive queue |
| cpuRxRdData | output | 32 | Receive queue head, 0 when empty |
| cpuRaIdx | input | 2 | Processor random-access entry index |
| cpuRaWrEn | input | 1 | Processor random-access write |
| cpuRaWrData | input | 32 | Processor random-access write word |
| cpuRaRdData | output | 32 | Processor random-access read word |
| smPullEn | input | 1 | Machine pull (pop) from transmit queue |
| smPullData | output | 32 | Transmit queue head, 0 when empty |
| smPushEn | input | 1 | Machine push to receive queue |
| smPushData | input | 32 | Machine push word |
| smPutEn | input | 1 | Machine random-access write |
| smPutIdx | input | 2 | Machine write entry index |
| smPutData | input | 32 | Machine write word |
| smGetIdx | input | 2 | Machine read entry index |
| smGetData | output | 32 | Machine random-access read word |
| txLevel | output | 4 | Transmit fill count |
| rxLevel | output | 4 | Receive fill count |
| txFull | output | 1 | Transmit full |
| txEmpty | output | 1 | Transmit empty |
| rxFull | output | 1 | Receive full |
| rxEmpty | output | 1 | Receive empty |
| dbgFlags | output | 4 | Sticky flags: 0 rx stall, 1 rx underflow, 2 tx overflow, 3 tx stall |
| dbgClr | input | 4 | Write-1-to-clear mask for the flags |
| statSel | input | 1 | Level-compare source: 0 transmit, 1 receive |
| statN | input | 4 | Level-compare threshold |
| statOut | output | 32 | All ones if the selected level is below statN |

## Verification
The two functions that meet in one cycle are a processor write and a machine pull on the transmit queue. The same applies to a push and a read on the receive queue. Their outcome depends on whether full and empty are judged before or after the edge. Random traffic hits these collisions at every fill level, including full, empty and the join modes. A directed case writes and pulls together on an empty transmit queue. The bench model judges every such cycle on the state before the edge and compares levels, head data and flags against the design each cycle.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int ADDR_MAX_W = 8;

  typedef enum logic [1:0] {
    RX_SRC_PUSH  = 2'd0,
    RX_SRC_SMPUT = 2'd1,
    RX_SRC_CPURA = 2'd2
  } rxSrc_e;

  typedef struct packed {
    logic                  txWr;
    logic [ADDR_MAX_W-1:0] txWrAddr;
    logic                  rxWr;
    rxSrc_e                rxSrc;
    logic [ADDR_MAX_W-1:0] rxWrAddr;
    logic                  txRdOk;
    logic [ADDR_MAX_W-1:0] txRdAddr;
    logic                  rxRdOk;
    logic [ADDR_MAX_W-1:0] rxRdAddr;
    logic                  cpuRaRdOk;
    logic                  smGetOk;
  } fqStrobe_t;
endpackage

// File: rtl/fifo_pair_ctrl.sv
module fifo_pair_ctrl
  import fifo_pair_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int TOT = 2 * DEPTH,
  localparam int PW  = $clog2(TOT),
  localparam int LW  = $clog2(TOT + 1),
  localparam int IW  = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgJoinTx,
  input  logic          cfgJoinRx,
  input  logic          cfgRaPut,
  input  logic          cfgRaGet,
  input  logic          cpuTxWrEn,
  input  logic          cpuRxRdEn,
  input  logic          smPullEn,
  input  logic          smPushEn,
  input  logic          smPutEn,
  input  logic          cpuRaWrEn,
  input  logic [IW-1:0] smPutIdx,
  input  logic [IW-1:0] cpuRaIdx,
  input  logic [3:0]    dbgClr,
  input  logic          statSel,
  input  logic [LW-1:0] statN,
  output fqStrobe_t     st,
  output logic [LW-1:0] txLevel,
  output logic [LW-1:0] rxLevel,
  output logic          txFull,
  output logic          txEmpty,
  output logic          rxFull,
  output logic          rxEmpty,
  output logic [3:0]    dbgFlags,
  output logic [DW-1:0] statOut
);
  localparam logic [LW-1:0] CAP1 = LW'(DEPTH);
  localparam logic [LW-1:0] CAP2 = LW'(TOT);

  logic raAny, jTx, jRx, flush;
  logic [2:0] modeNow, modePrev;
  logic [LW-1:0] txCap, rxCap, txCnt, rxCnt, selLvl;
  logic [PW-1:0] txRp, rxRp, rxBase;
  logic txDoWr, txDoRd, rxDoWr, rxDoRd, raSmWr, raCpuWr;
  logic [3:0] flagSet;

  function automatic logic [PW-1:0] wrapAdd(logic [PW-1:0] p, logic [LW-1:0] n, logic [LW-1:0] cap);
    logic [LW:0] s;
    s = (LW+1)'(p) + (LW+1)'(n);
    if (s >= (LW+1)'(cap)) s = s - (LW+1)'(cap);
    return s[PW-1:0];
  endfunction

  always_comb begin
    raAny   = cfgRaPut | cfgRaGet;
    jTx     = cfgJoinTx & ~raAny;
    jRx     = cfgJoinRx & ~cfgJoinTx & ~raAny;
    modeNow = {jTx, jRx, raAny};
    flush   = (modeNow != modePrev);
    txCap   = jRx ? '0 : (jTx ? CAP2 : CAP1);
    rxCap   = (jTx | raAny) ? '0 : (jRx ? CAP2 : CAP1);
    rxBase  = jRx ? '0 : PW'(DEPTH);
    txFull  = (txCnt == txCap);
    txEmpty = (txCnt == '0);
    rxFull  = (rxCnt == rxCap);
    rxEmpty = (rxCnt == '0);
    txDoWr  = cpuTxWrEn & ~txFull & ~flush;
    txDoRd  = smPullEn & ~txEmpty & ~flush;
    rxDoWr  = smPushEn & ~rxFull & ~flush;
    rxDoRd  = cpuRxRdEn & ~rxEmpty & ~flush;
    raSmWr  = smPutEn & cfgRaPut & ~flush;
    raCpuWr = cpuRaWrEn & cfgRaGet & ~cfgRaPut & ~flush;
    // bit0 rx stall, bit1 rx underflow, bit2 tx overflow, bit3 tx stall
    flagSet = {smPullEn & txEmpty, cpuTxWrEn & txFull,
               cpuRxRdEn & rxEmpty, smPushEn & rxFull} & {4{~flush}};
  end

  always_comb begin
    st           = '0;
    st.txWr      = txDoWr;
    st.txWrAddr  = ADDR_MAX_W'(wrapAdd(txRp, txCnt, txCap));
    st.txRdOk    = ~txEmpty & ~flush;
    st.txRdAddr  = ADDR_MAX_W'(txRp);
    st.rxRdOk    = ~rxEmpty & ~flush;
    st.rxRdAddr  = ADDR_MAX_W'(rxBase + rxRp);
    st.rxWr      = rxDoWr | raSmWr | raCpuWr;
    st.cpuRaRdOk = cfgRaPut & ~cfgRaGet & ~flush;
    st.smGetOk   = cfgRaGet & ~flush;
    if (raSmWr) begin
      st.rxSrc    = RX_SRC_SMPUT;
      st.rxWrAddr = ADDR_MAX_W'(PW'(DEPTH) + PW'(smPutIdx));
    end else if (raCpuWr) begin
      st.rxSrc    = RX_SRC_CPURA;
      st.rxWrAddr = ADDR_MAX_W'(PW'(DEPTH) + PW'(cpuRaIdx));
    end else begin
      st.rxSrc    = RX_SRC_PUSH;
      st.rxWrAddr = ADDR_MAX_W'(rxBase + wrapAdd(rxRp, rxCnt, rxCap));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePrev <= '0;
      txCnt    <= '0;
      rxCnt    <= '0;
      txRp     <= '0;
      rxRp     <= '0;
      dbgFlags <= '0;
    end else begin
      modePrev <= modeNow;
      dbgFlags <= flagSet | (dbgFlags & ~dbgClr);
      if (flush) begin
        txCnt <= '0;
        rxCnt <= '0;
        txRp  <= '0;
        rxRp  <= '0;
      end else begin
        txCnt <= txCnt + LW'(txDoWr) - LW'(txDoRd);
        rxCnt <= rxCnt + LW'(rxDoWr) - LW'(rxDoRd);
        if (txDoRd) txRp <= wrapAdd(txRp, LW'(1), txCap);
        if (rxDoRd) rxRp <= wrapAdd(rxRp, LW'(1), rxCap);
      end
    end
  end

  always_comb begin
    txLevel = txCnt;
    rxLevel = rxCnt;
    selLvl  = statSel ? rxCnt : txCnt;
    statOut = (selLvl < statN) ? '1 : '0;
  end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    !flush |-> (txCnt <= txCap) && (rxCnt <= rxCap));
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (txCnt == '0) && (rxCnt == '0));
  assert_drop_on_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuTxWrEn && txFull && !smPullEn && !flush) |=> $stable(txCnt) && dbgFlags[2]);
  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dbgFlags[0] && !dbgClr[0]) |=> dbgFlags[0]);
  assert_ra_rx_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (raAny && !flush) |-> (rxCnt == '0));
endmodule

// File: rtl/fifo_pair_dpath.sv
module fifo_pair_dpath
  import fifo_pair_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int TOT = 2 * DEPTH,
  localparam int PW  = $clog2(TOT),
  localparam int IW  = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fqStrobe_t     st,
  input  logic [DW-1:0] txWrData,
  input  logic [DW-1:0] smPushData,
  input  logic [DW-1:0] smPutData,
  input  logic [DW-1:0] cpuRaWrData,
  input  logic [IW-1:0] smGetIdx,
  input  logic [IW-1:0] cpuRaIdx,
  output logic [DW-1:0] smPullData,
  output logic [DW-1:0] cpuRxRdData,
  output logic [DW-1:0] smGetData,
  output logic [DW-1:0] cpuRaRdData
);
  logic [DW-1:0] mem [TOT];
  logic [DW-1:0] rxWrData;

  always_comb begin
    unique case (st.rxSrc)
      RX_SRC_SMPUT: rxWrData = smPutData;
      RX_SRC_CPURA: rxWrData = cpuRaWrData;
      default:      rxWrData = smPushData;
    endcase
  end

  for (genvar g = 0; g < TOT; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mem[g] <= '0;
      else if (st.txWr && st.txWrAddr[PW-1:0] == PW'(g))
        mem[g] <= txWrData;
      else if (st.rxWr && st.rxWrAddr[PW-1:0] == PW'(g))
        mem[g] <= rxWrData;
    end
  end

  always_comb begin
    smPullData  = st.txRdOk    ? mem[st.txRdAddr[PW-1:0]] : '0;
    cpuRxRdData = st.rxRdOk    ? mem[st.rxRdAddr[PW-1:0]] : '0;
    smGetData   = st.smGetOk   ? mem[PW'(DEPTH) + PW'(smGetIdx)] : '0;
    cpuRaRdData = st.cpuRaRdOk ? mem[PW'(DEPTH) + PW'(cpuRaIdx)] : '0;
  end

  assert_port_clash_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(st.txWr && st.rxWr && st.txWrAddr == st.rxWrAddr));
endmodule

// File: rtl/fifo_pair_join.sv
module fifo_pair_join
  import fifo_pair_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int LW  = $clog2(2 * DEPTH + 1),
  localparam int IW  = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgJoinTx,
  input  logic          cfgJoinRx,
  input  logic          cfgRaPut,
  input  logic          cfgRaGet,
  input  logic          cpuTxWrEn,
  input  logic [DW-1:0] cpuTxWrData,
  input  logic          cpuRxRdEn,
  output logic [DW-1:0] cpuRxRdData,
  input  logic [IW-1:0] cpuRaIdx,
  input  logic          cpuRaWrEn,
  input  logic [DW-1:0] cpuRaWrData,
  output logic [DW-1:0] cpuRaRdData,
  input  logic          smPullEn,
  output logic [DW-1:0] smPullData,
  input  logic          smPushEn,
  input  logic [DW-1:0] smPushData,
  input  logic          smPutEn,
  input  logic [IW-1:0] smPutIdx,
  input  logic [DW-1:0] smPutData,
  input  logic [IW-1:0] smGetIdx,
  output logic [DW-1:0] smGetData,
  output logic [LW-1:0] txLevel,
  output logic [LW-1:0] rxLevel,
  output logic          txFull,
  output logic          txEmpty,
  output logic          rxFull,
  output logic          rxEmpty,
  output logic [3:0]    dbgFlags,
  input  logic [3:0]    dbgClr,
  input  logic          statSel,
  input  logic [LW-1:0] statN,
  output logic [DW-1:0] statOut
);
  fqStrobe_t st;

  fifo_pair_ctrl #(.DW(DW), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgJoinTx(cfgJoinTx), .cfgJoinRx(cfgJoinRx), .cfgRaPut(cfgRaPut), .cfgRaGet(cfgRaGet),
    .cpuTxWrEn(cpuTxWrEn), .cpuRxRdEn(cpuRxRdEn), .smPullEn(smPullEn), .smPushEn(smPushEn),
    .smPutEn(smPutEn), .cpuRaWrEn(cpuRaWrEn), .smPutIdx(smPutIdx), .cpuRaIdx(cpuRaIdx),
    .dbgClr(dbgClr), .statSel(statSel), .statN(statN), .st(st),
    .txLevel(txLevel), .rxLevel(rxLevel), .txFull(txFull), .txEmpty(txEmpty),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .dbgFlags(dbgFlags), .statOut(statOut)
  );

  fifo_pair_dpath #(.DW(DW), .DEPTH(DEPTH)) uDpath (
    .clk(clk), .rstN(rstN), .st(st),
    .txWrData(cpuTxWrData), .smPushData(smPushData), .smPutData(smPutData),
    .cpuRaWrData(cpuRaWrData), .smGetIdx(smGetIdx), .cpuRaIdx(cpuRaIdx),
    .smPullData(smPullData), .cpuRxRdData(cpuRxRdData),
    .smGetData(smGetData), .cpuRaRdData(cpuRaRdData)
  );
endmodule

// File: tb/sim_fifo_pair_join.sv
`timescale 1ns/1ps
module sim_fifo_pair_join;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic joinTx = 0, joinRx = 0, raPut = 0, raGet = 0;
  logic txWr = 0, rxRd = 0, raWr = 0, pull = 0, push = 0, put = 0;
  logic [31:0] txData = 0, raData = 0, pushData = 0, putData = 0;
  logic [1:0] raIdx = 0, putIdx = 0, getIdx = 0;
  logic [3:0] clr = 0, statN = 0;
  logic statSel = 0;

  logic [31:0] rxRdData, raRdData, pullData, getData, statOut;
  logic [3:0] txLevel, rxLevel, flags;
  logic txFull, txEmpty, rxFull, rxEmpty;

  fifo_pair_join u0 (
    .clk(clk), .rstN(rstN),
    .cfgJoinTx(joinTx), .cfgJoinRx(joinRx), .cfgRaPut(raPut), .cfgRaGet(raGet),
    .cpuTxWrEn(txWr), .cpuTxWrData(txData), .cpuRxRdEn(rxRd), .cpuRxRdData(rxRdData),
    .cpuRaIdx(raIdx), .cpuRaWrEn(raWr), .cpuRaWrData(raData), .cpuRaRdData(raRdData),
    .smPullEn(pull), .smPullData(pullData), .smPushEn(push), .smPushData(pushData),
    .smPutEn(put), .smPutIdx(putIdx), .smPutData(putData), .smGetIdx(getIdx),
    .smGetData(getData), .txLevel(txLevel), .rxLevel(rxLevel), .txFull(txFull),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty), .dbgFlags(flags),
    .dbgClr(clr), .statSel(statSel), .statN(statN), .statOut(statOut)
  );

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [31:0] txQ[$];
  logic [31:0] rxQ[$];
  logic [3:0] mFlags = 0;
  logic [2:0] mPrev = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: called just after a falling edge with inputs set
  task automatic cyc();
    logic ra, jT, jR, fl, tF, tE, rF, rE;
    logic [2:0] mode;
    int tc, rc, lvl;
    logic [3:0] ev;
    #2;
    ra = raPut | raGet;
    jT = joinTx & ~ra;
    jR = joinRx & ~joinTx & ~ra;
    mode = {jT, jR, ra};
    fl = (mode != mPrev);
    tc = jR ? 0 : (jT ? 8 : 4);
    rc = (jT | ra) ? 0 : (jR ? 8 : 4);
    tF = (txQ.size() == tc); tE = (txQ.size() == 0);
    rF = (rxQ.size() == rc); rE = (rxQ.size() == 0);
    chk("R1/R3 txLevel", 32'(txLevel), 32'(txQ.size()));
    chk("R2/R4 rxLevel", 32'(rxLevel), 32'(rxQ.size()));
    chk("R1/R4 txFull", 32'(txFull), 32'(tF));
    chk("R1 txEmpty", 32'(txEmpty), 32'(tE));
    chk("R2/R3 rxFull", 32'(rxFull), 32'(rF));
    chk("R2 rxEmpty", 32'(rxEmpty), 32'(rE));
    chk("R1/R12 pull data", pullData, (fl || tE) ? 32'h0 : txQ[0]);
    chk("R2 cpu read data", rxRdData, (fl || rE) ? 32'h0 : rxQ[0]);
    chk("R6/R7/R8 flags", 32'(flags), 32'(mFlags));
    lvl = statSel ? rxQ.size() : txQ.size();
    chk("R11 statOut", statOut, (lvl < int'(statN)) ? 32'hFFFF_FFFF : 32'h0);
    ev = fl ? 4'h0 : {pull & tE, txWr & tF, rxRd & rE, push & rF};
    mFlags = ev | (mFlags & ~clr);
    if (fl) begin
      txQ.delete(); rxQ.delete();
    end else begin
      if (pull && !tE) void'(txQ.pop_front());
      if (txWr && !tF) txQ.push_back(txData);
      if (rxRd && !rE) void'(rxQ.pop_front());
      if (push && !rF) rxQ.push_back(pushData);
    end
    mPrev = mode;
    @(negedge clk);
    txWr = 0; rxRd = 0; pull = 0; push = 0; put = 0; raWr = 0; clr = 0;
  endtask

  task automatic setMode(logic jt, logic jr, logic rp, logic rg);
    joinTx = jt; joinRx = jr; raPut = rp; raGet = rg;
    cyc();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5a_e0c3));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state, R1 R2 R11
    statN = 4'd1;
    cyc();
    chk("R1 reset txEmpty", 32'(txEmpty), 32'd1);
    chk("R8 reset flags", 32'(flags), 32'd0);
    // fill TX with one extra write: R6
    for (int i = 0; i < 5; i++) begin txWr = 1; txData = 32'hA000 + i; cyc(); end
    chk("R6 overflow flag", 32'(flags[2]), 32'd1);
    chk("R6 level kept", 32'(txLevel), 32'd4);
    for (int i = 0; i < 4; i++) begin pull = 1; cyc(); end
    pull = 1; #1;
    chk("R7 pull empty data", pullData, 32'h0);
    cyc();
    chk("R7 tx stall flag", 32'(flags[3]), 32'd1);
    rxRd = 1; cyc();
    chk("R7 rx underflow flag", 32'(flags[1]), 32'd1);
    // R8 clear all while a new stall event arrives
    clr = 4'hF; pull = 1; cyc();
    chk("R8 set wins over clear", 32'(flags), 32'h8);
    // R12 write and pull on empty queue
    txWr = 1; txData = 32'hBEEF; pull = 1; cyc();
    chk("R12 level after collision", 32'(txLevel), 32'd1);
    push = 1; pushData = 32'h11; cyc();
    push = 1; pushData = 32'h22; cyc();
    // R5 flush on join change
    setMode(1, 0, 0, 0);
    chk("R5 tx flushed", 32'(txLevel), 32'd0);
    chk("R5 rx flushed", 32'(rxLevel), 32'd0);
    // R3 transmit join
    for (int i = 0; i < 8; i++) begin txWr = 1; txData = 32'hC000 + i; cyc(); end
    chk("R3 tx full at 8", 32'(txFull), 32'd1);
    chk("R3 rx full and empty", 32'({rxFull, rxEmpty}), 32'd3);
    for (int i = 0; i < 8; i++) begin pull = 1; cyc(); end
    // R4 receive join
    setMode(0, 1, 0, 0);
    for (int i = 0; i < 8; i++) begin push = 1; pushData = 32'hD000 + i; cyc(); end
    chk("R4 rx full at 8", 32'(rxFull), 32'd1);
    chk("R4 tx full and empty", 32'({txFull, txEmpty}), 32'd3);
    for (int i = 0; i < 8; i++) begin rxRd = 1; cyc(); end
    // R9 R10 random access, get only, join bits also set
    setMode(1, 1, 0, 1);
    chk("R9 rx full and empty", 32'({rxFull, rxEmpty}), 32'd3);
    for (int i = 0; i < 5; i++) begin txWr = 1; txData = 32'hE000 + i; cyc(); end
    chk("R9 tx keeps 4 entries", 32'(txLevel), 32'd4);
    for (int i = 0; i < 4; i++) begin raWr = 1; raIdx = 2'(i); raData = 32'hF000 + i; cyc(); end
    for (int i = 0; i < 4; i++) begin
      getIdx = 2'(i); raIdx = 2'(i); #1;
      chk("R10 get reads cpu write", getData, 32'hF000 + i);
      chk("R10 cpu read blocked in get mode", raRdData, 32'h0);
    end
    // put only: same random-access mode, no flush
    setMode(1, 1, 1, 0);
    put = 1; putIdx = 2'd1; putData = 32'h55; cyc();
    raIdx = 2'd1; #1;
    chk("R10 cpu reads machine put", raRdData, 32'h55);
    raIdx = 2'd2; #1;
    chk("R10 cpu reads old entry", raRdData, 32'hF002);
    getIdx = 2'd1; #1;
    chk("R10 get off returns 0", getData, 32'h0);
    // both on: processor locked out
    setMode(1, 1, 1, 1);
    raWr = 1; raIdx = 2'd2; raData = 32'h99; cyc();
    put = 1; putIdx = 2'd3; putData = 32'h77; cyc();
    getIdx = 2'd2; #1;
    chk("R10 cpu write ignored", getData, 32'hF002);
    getIdx = 2'd3; #1;
    chk("R10 machine put then get", getData, 32'h77);
    raIdx = 2'd3; #1;
    chk("R10 cpu read blocked in both mode", raRdData, 32'h0);
    setMode(0, 0, 0, 0);
    // constrained random traffic across modes
    for (int n = 0; n < 3000; n++) begin
      if (n % 250 == 0) begin
        case ($urandom_range(4))
          0: begin joinTx = 0; joinRx = 0; raPut = 0; raGet = 0; end
          1: begin joinTx = 1; joinRx = 0; raPut = 0; raGet = 0; end
          2: begin joinTx = 0; joinRx = 1; raPut = 0; raGet = 0; end
          3: begin joinTx = 1; joinRx = 1; raPut = 0; raGet = 0; end
          default: begin joinTx = 1; joinRx = 0; raPut = 0; raGet = 1; end
        endcase
      end
      txWr = 1'($urandom_range(1)); txData = $urandom;
      pull = 1'($urandom_range(1));
      push = 1'($urandom_range(1)); pushData = $urandom;
      rxRd = 1'($urandom_range(1));
      clr = ($urandom_range(7) == 0) ? 4'($urandom) : 4'h0;
      statSel = 1'($urandom_range(1)); statN = 4'($urandom_range(9));
      cyc();
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule